// File: doc/BRIEF.md
# Dual-Issue Packet Dispatcher

This block accepts one 64-bit instruction packet at a time and splits it into the work its two execution units see. Two format bits inside the packet decide the shape. The packet is either a pair that runs side by side, a pair that runs upper half first, a pair that runs lower half first, or one wide instruction that fills the whole packet. Each sub-instruction is presented on a single issue port together with a unit selection. The execution side answers each issue with a done handshake. The answer carries a branch indication and target, a kill-second flag and a system-move flag.

Once the packet is finished, the block reports one merged next-PC result: a branch flag with its target, or no branch. A separate conflict flag is raised when both halves of a side-by-side pair branch. A one-cycle commit pulse tells the downstream write-commit arbiter when queued results may be retired. A sequential pair produces one pulse per executed step. A side-by-side pair produces a single pulse after both halves. The kill and system-move flags captured from the first issue are held visible for the remainder of the packet, so the arbiter can resolve flag contention.

The sequencer has four states. **IDLE** waits for a packet and takes it (transition *accept*, IDLE to ISSUE1). **ISSUE1** presents the first sub-instruction. When its done arrives, the sequencer makes one of two transitions. *Finish-early* (ISSUE1 to DONE) is taken for a wide instruction, or for a sequential pair whose first step branched or killed the second. *Advance* (ISSUE1 to ISSUE2) is taken otherwise. **ISSUE2** presents the second sub-instruction and leaves on done (transition *complete*, ISSUE2 to DONE). **DONE** shows the result for one cycle and returns (transition *retire*, DONE to IDLE).

Top module: `pair_dispatch`

## Requirements
- R1: After reset, `pkt_ready` is 1 and every other output is 0.
- R2: The format is decoded as `{pkt_data[63], pkt_data[31]}`. Value 0 is side-by-side, 1 is upper-first, 2 is lower-first and 3 is wide. Unit codes are 0 any, 1 memory and 2 integer.
- R3: For upper-first, bits 63:32 issue first on unit 1, then bits 31:0 issue on unit 0. Short halves appear zero-extended on `iss_word`.
- R4: For lower-first, bits 31:0 issue first on unit 2, then bits 63:32 issue on unit 0.
- R5: For wide, the full packet issues once with `iss_long`=1 and unit 0. The result is the branch answer of that single issue.
- R6: In a sequential pair, the second half is not issued if the first answered with `iss_branch` or `iss_kill`. The packet then goes straight to the result.
- R7: For side-by-side, bits 63:32 issue on unit 1 and then bits 31:0 on unit 2, whatever the first answer was.
- R8: Side-by-side merge works as follows. No branch in either half gives no branch. Exactly one branch gives that half's target. Two branches raise `res_conflict` with `res_branch`=0 and `res_pc`=0.
- R9: The sequential result is the first half's target if it branched, else the second half's target if it branched, else no branch with `res_pc`=0.
- R10: `commit` is a one-cycle pulse in the cycle after a done. There is one pulse per executed step of a sequential or wide packet, and only one pulse after the second done of a side-by-side packet.
- R11: `iss_valid` holds with unchanged word and unit until `iss_done`. `pkt_valid` is ignored while `pkt_ready`=0.
- R12: `kill_flag` and `sys_flag` take the first issue's `iss_kill`/`iss_sys` at its done. They hold through the result cycle and are 0 whenever `pkt_ready`=1.
- R13: `res_valid` is high for exactly the cycle after the last done, and result outputs are 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_data | input | 64 | Instruction packet |
| pkt_ready | output | 1 | Block idle, packet taken when valid |
| iss_valid | output | 1 | Sub-instruction presented |
| iss_word | output | 64 | Issued word (short halves zero-extended) |
| iss_long | output | 1 | Issued word is a wide instruction |
| iss_unit | output | 2 | Unit selection: 0 any, 1 memory, 2 integer |
| iss_done | input | 1 | Execution of the presented word finished |
| iss_branch | input | 1 | Presented word produced a branch |
| iss_target | input | 32 | Branch target of the presented word |
| iss_kill | input | 1 | First word cancels the second |
| iss_sys | input | 1 | First word was a system-register move |
| kill_flag | output | 1 | Held kill flag of the current packet |
| sys_flag | output | 1 | Held system-move flag of the current packet |
| commit | output | 1 | Write-commit pulse |
| res_valid | output | 1 | Merged result present |
| res_branch | output | 1 | Merged result is a branch |
| res_pc | output | 32 | Merged branch target |
| res_conflict | output | 1 | Both side-by-side halves branched |

## Verification
Each of the four formats is driven with packets whose upper and lower halves differ. Checking the issued word against the unit selection therefore separates correct half ordering from swapped or mis-routed halves. Sequential pairs are answered first with no branch, then with a first-half branch, then with only a kill flag, and then with a second-half branch. These cases tell cancellation apart from pass-through and show which target wins. Side-by-side pairs run through all four branch combinations, which separates the single-target cases from the conflict case. Variable done latencies, stray packets offered while busy, and back-to-back random packets expose commit pulses that are mistimed or missing, and flags that leak past the end of a packet.

// File: rtl/pdisp_pkg.sv
package pdisp_pkg;

    typedef enum logic [1:0] {
        FMT_PAIR        = 2'd0,
        FMT_UPPER_FIRST = 2'd1,
        FMT_LOWER_FIRST = 2'd2,
        FMT_WIDE        = 2'd3
    } pkt_fmt_e;

    typedef enum logic [1:0] {
        UNIT_ANY = 2'd0,
        UNIT_MEM = 2'd1,
        UNIT_INT = 2'd2
    } unit_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE1 = 2'd1,
        ST_ISSUE2 = 2'd2,
        ST_DONE   = 2'd3
    } disp_state_e;

endpackage

// File: rtl/pdisp_classify.sv
module pdisp_classify
    import pdisp_pkg::*;
#(
    parameter int PKT_W = 64
) (
    input  logic [PKT_W-1:0] pkt,
    output pkt_fmt_e         fmt,
    output logic [PKT_W-1:0] word_a,
    output unit_sel_e        unit_a,
    output logic             wide_a,
    output logic [PKT_W-1:0] word_b,
    output unit_sel_e        unit_b
);
    localparam int HALF_W = PKT_W / 2;

    logic [HALF_W-1:0] upper_half;
    logic [HALF_W-1:0] lower_half;
    logic [PKT_W-1:0]  upper_ext;
    logic [PKT_W-1:0]  lower_ext;

    always_comb begin
        upper_half = pkt[PKT_W-1:HALF_W];
        lower_half = pkt[HALF_W-1:0];
        upper_ext  = {{HALF_W{1'b0}}, upper_half};
        lower_ext  = {{HALF_W{1'b0}}, lower_half};
        // format bits: leading bit of each half, first half is the high bit
        fmt        = pkt_fmt_e'({pkt[PKT_W-1], pkt[HALF_W-1]});
    end

    always_comb begin
        word_a = '0;
        unit_a = UNIT_ANY;
        wide_a = 1'b0;
        word_b = '0;
        unit_b = UNIT_ANY;
        unique case (fmt)
            FMT_PAIR: begin
                word_a = upper_ext;
                unit_a = UNIT_MEM;
                word_b = lower_ext;
                unit_b = UNIT_INT;
            end
            FMT_UPPER_FIRST: begin
                word_a = upper_ext;
                unit_a = UNIT_MEM;
                word_b = lower_ext;
                unit_b = UNIT_ANY;
            end
            FMT_LOWER_FIRST: begin
                word_a = lower_ext;
                unit_a = UNIT_INT;
                word_b = upper_ext;
                unit_b = UNIT_ANY;
            end
            FMT_WIDE: begin
                word_a = pkt;
                unit_a = UNIT_ANY;
                wide_a = 1'b1;
            end
            default: begin
                word_a = '0;
            end
        endcase
    end

endmodule

// File: rtl/pdisp_merge.sv
module pdisp_merge
    import pdisp_pkg::*;
#(
    parameter int AW = 32
) (
    input  pkt_fmt_e         fmt,
    input  logic             br_a,
    input  logic [AW-1:0]    tgt_a,
    input  logic             br_b,
    input  logic [AW-1:0]    tgt_b,
    output logic             taken,
    output logic [AW-1:0]    pc,
    output logic             conflict
);
    always_comb begin
        taken    = 1'b0;
        pc       = '0;
        conflict = 1'b0;
        if (fmt == FMT_PAIR) begin
            // side-by-side: exactly one branch wins, two branches clash
            conflict = br_a & br_b;
            taken    = br_a ^ br_b;
            if (br_a && !br_b) begin
                pc = tgt_a;
            end else if (br_b && !br_a) begin
                pc = tgt_b;
            end
        end else begin
            // sequential or wide: earliest executed branch wins
            if (br_a) begin
                taken = 1'b1;
                pc    = tgt_a;
            end else if (br_b) begin
                taken = 1'b1;
                pc    = tgt_b;
            end
        end
    end

endmodule

// File: rtl/pdisp_seq.sv
module pdisp_seq
    import pdisp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pkt_valid,
    input  pkt_fmt_e    fmt,
    input  logic        iss_done,
    input  logic        iss_branch,
    input  logic        iss_kill,
    output disp_state_e state,
    output logic        accept,
    output logic        done_a,
    output logic        done_b,
    output logic        finish,
    output logic        commit
);
    disp_state_e state_nx;
    logic        cut_short;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        cut_short = (fmt == FMT_WIDE) ||
                    ((fmt != FMT_PAIR) && (iss_branch || iss_kill));
        state_nx  = state;
        unique case (state)
            ST_IDLE:   if (pkt_valid) state_nx = ST_ISSUE1;
            ST_ISSUE1: if (iss_done)  state_nx = cut_short ? ST_DONE : ST_ISSUE2;
            ST_ISSUE2: if (iss_done)  state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        done_a = 1'b0;
        done_b = 1'b0;
        finish = 1'b0;
        unique case (state)
            ST_IDLE:   accept = pkt_valid;
            ST_ISSUE1: done_a = iss_done;
            ST_ISSUE2: done_b = iss_done;
            ST_DONE:   finish = 1'b1;
            default:   finish = 1'b0;
        endcase
    end

    // commit follows each executed step, except the first half of a pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit <= 1'b0;
        end else begin
            commit <= done_b || (done_a && (fmt != FMT_PAIR));
        end
    end

endmodule

// File: rtl/pair_dispatch.sv
module pair_dispatch
    import pdisp_pkg::*;
#(
    parameter int PKT_W = 64,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [PKT_W-1:0] pkt_data,
    output logic             pkt_ready,
    output logic             iss_valid,
    output logic [PKT_W-1:0] iss_word,
    output logic             iss_long,
    output logic [1:0]       iss_unit,
    input  logic             iss_done,
    input  logic             iss_branch,
    input  logic [AW-1:0]    iss_target,
    input  logic             iss_kill,
    input  logic             iss_sys,
    output logic             kill_flag,
    output logic             sys_flag,
    output logic             commit,
    output logic             res_valid,
    output logic             res_branch,
    output logic [AW-1:0]    res_pc,
    output logic             res_conflict
);
    disp_state_e      state;
    logic             accept, done_a, done_b, finish;
    logic [PKT_W-1:0] pkt_q;
    pkt_fmt_e         fmt;
    logic [PKT_W-1:0] word_a, word_b;
    unit_sel_e        unit_a, unit_b;
    logic             wide_a;
    logic             br_a_q, br_b_q;
    logic [AW-1:0]    tgt_a_q, tgt_b_q;
    logic             kill_q, sys_q;
    logic             m_taken, m_conflict;
    logic [AW-1:0]    m_pc;

    pdisp_classify #(.PKT_W(PKT_W)) u_classify (
        .pkt    (pkt_q),
        .fmt    (fmt),
        .word_a (word_a),
        .unit_a (unit_a),
        .wide_a (wide_a),
        .word_b (word_b),
        .unit_b (unit_b)
    );

    pdisp_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_valid  (pkt_valid),
        .fmt        (fmt),
        .iss_done   (iss_done),
        .iss_branch (iss_branch),
        .iss_kill   (iss_kill),
        .state      (state),
        .accept     (accept),
        .done_a     (done_a),
        .done_b     (done_b),
        .finish     (finish),
        .commit     (commit)
    );

    pdisp_merge #(.AW(AW)) u_merge (
        .fmt      (fmt),
        .br_a     (br_a_q),
        .tgt_a    (tgt_a_q),
        .br_b     (br_b_q),
        .tgt_b    (tgt_b_q),
        .taken    (m_taken),
        .pc       (m_pc),
        .conflict (m_conflict)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_q   <= '0;
            br_a_q  <= 1'b0;
            br_b_q  <= 1'b0;
            tgt_a_q <= '0;
            tgt_b_q <= '0;
            kill_q  <= 1'b0;
            sys_q   <= 1'b0;
        end else begin
            if (accept) begin
                pkt_q   <= pkt_data;
                br_a_q  <= 1'b0;
                br_b_q  <= 1'b0;
                tgt_a_q <= '0;
                tgt_b_q <= '0;
                kill_q  <= 1'b0;
                sys_q   <= 1'b0;
            end
            if (done_a) begin
                br_a_q  <= iss_branch;
                tgt_a_q <= iss_target;
                kill_q  <= iss_kill;
                sys_q   <= iss_sys;
            end
            if (done_b) begin
                br_b_q  <= iss_branch;
                tgt_b_q <= iss_target;
            end
            if (finish) begin
                kill_q <= 1'b0;
                sys_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        pkt_ready    = 1'b0;
        iss_valid    = 1'b0;
        iss_word     = '0;
        iss_long     = 1'b0;
        iss_unit     = UNIT_ANY;
        res_valid    = 1'b0;
        res_branch   = 1'b0;
        res_pc       = '0;
        res_conflict = 1'b0;
        kill_flag    = kill_q;
        sys_flag     = sys_q;
        unique case (state)
            ST_IDLE: begin
                pkt_ready = 1'b1;
            end
            ST_ISSUE1: begin
                iss_valid = 1'b1;
                iss_word  = word_a;
                iss_long  = wide_a;
                iss_unit  = unit_a;
            end
            ST_ISSUE2: begin
                iss_valid = 1'b1;
                iss_word  = word_b;
                iss_unit  = unit_b;
            end
            ST_DONE: begin
                res_valid    = 1'b1;
                res_branch   = m_taken;
                res_pc       = m_pc;
                res_conflict = m_conflict;
            end
            default: begin
                pkt_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pdisp_checks.sv
module pdisp_checks #(
    parameter int PKT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_ready,
    input logic             iss_valid,
    input logic [PKT_W-1:0] iss_word,
    input logic             iss_long,
    input logic [1:0]       iss_unit,
    input logic             iss_done,
    input logic             kill_flag,
    input logic             sys_flag,
    input logic             commit,
    input logic             res_valid,
    input logic             res_branch,
    input logic             res_conflict
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (!iss_valid && !res_valid));

    assert_unit_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_unit != 2'd3);

    assert_wide_any_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_long) |-> (iss_unit == 2'd0));

    assert_conflict_no_branch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_conflict |-> (res_valid && !res_branch));

    assert_commit_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(iss_done && iss_valid));

    assert_issue_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_done) |=> (iss_valid && $stable(iss_word) && $stable(iss_unit)));

    assert_flags_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (!kill_flag && !sys_flag));

    assert_result_after_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(iss_done && iss_valid));

    assert_result_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

endmodule

bind pair_dispatch pdisp_checks #(.PKT_W(PKT_W)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .pkt_ready    (pkt_ready),
    .iss_valid    (iss_valid),
    .iss_word     (iss_word),
    .iss_long     (iss_long),
    .iss_unit     (iss_unit),
    .iss_done     (iss_done),
    .kill_flag    (kill_flag),
    .sys_flag     (sys_flag),
    .commit       (commit),
    .res_valid    (res_valid),
    .res_branch   (res_branch),
    .res_conflict (res_conflict)
);

// File: tb/test_pair_dispatch.sv
`timescale 1ns/1ps
module test_pair_dispatch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [63:0] pkt_data = '0;
    logic        pkt_ready;
    logic        iss_valid;
    logic [63:0] iss_word;
    logic        iss_long;
    logic [1:0]  iss_unit;
    logic        iss_done = 1'b0;
    logic        iss_branch = 1'b0;
    logic [31:0] iss_target = '0;
    logic        iss_kill = 1'b0;
    logic        iss_sys = 1'b0;
    logic        kill_flag, sys_flag, commit;
    logic        res_valid, res_branch, res_conflict;
    logic [31:0] res_pc;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // expected port values for the current cycle
    logic        e_ready, e_ivalid, e_long, e_kill, e_sys, e_commit;
    logic        e_rvalid, e_rbr, e_rconf;
    logic [1:0]  e_unit;
    logic [63:0] e_word;
    logic [31:0] e_rpc;

    always #2.5 clk = ~clk;

    pair_dispatch i_pair_dispatch (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_ready(pkt_ready), .iss_valid(iss_valid), .iss_word(iss_word),
        .iss_long(iss_long), .iss_unit(iss_unit), .iss_done(iss_done),
        .iss_branch(iss_branch), .iss_target(iss_target), .iss_kill(iss_kill),
        .iss_sys(iss_sys), .kill_flag(kill_flag), .sys_flag(sys_flag),
        .commit(commit), .res_valid(res_valid), .res_branch(res_branch),
        .res_pc(res_pc), .res_conflict(res_conflict)
    );

    task automatic fail(input string tag, input string name,
                        input logic [63:0] act, input logic [63:0] exp);
        miscompares++;
        $display("FAIL %s %s actual=%h expected=%h at %0t", tag, name, act, exp, $time);
    endtask

    task automatic quiet_exp();
        e_ready = 0; e_ivalid = 0; e_long = 0; e_kill = 0; e_sys = 0;
        e_commit = 0; e_rvalid = 0; e_rbr = 0; e_rconf = 0;
        e_unit = 0; e_word = '0; e_rpc = '0;
    endtask

    // compare every output, then advance one clock (called at negedge)
    task automatic step(input string tag);
        vectors++;
        if (pkt_ready    !== e_ready)  fail(tag, "pkt_ready",    64'(pkt_ready),    64'(e_ready));
        if (iss_valid    !== e_ivalid) fail(tag, "iss_valid",    64'(iss_valid),    64'(e_ivalid));
        if (iss_word     !== e_word)   fail(tag, "iss_word",     iss_word,          e_word);
        if (iss_long     !== e_long)   fail(tag, "iss_long",     64'(iss_long),     64'(e_long));
        if (iss_unit     !== e_unit)   fail(tag, "iss_unit",     64'(iss_unit),     64'(e_unit));
        if (kill_flag    !== e_kill)   fail(tag, "kill_flag",    64'(kill_flag),    64'(e_kill));
        if (sys_flag     !== e_sys)    fail(tag, "sys_flag",     64'(sys_flag),     64'(e_sys));
        if (commit       !== e_commit) fail(tag, "commit",       64'(commit),       64'(e_commit));
        if (res_valid    !== e_rvalid) fail(tag, "res_valid",    64'(res_valid),    64'(e_rvalid));
        if (res_branch   !== e_rbr)    fail(tag, "res_branch",   64'(res_branch),   64'(e_rbr));
        if (res_pc       !== e_rpc)    fail(tag, "res_pc",       64'(res_pc),       64'(e_rpc));
        if (res_conflict !== e_rconf)  fail(tag, "res_conflict", 64'(res_conflict), 64'(e_rconf));
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic respond(input logic d, input logic b, input logic [31:0] t,
                           input logic k, input logic s);
        iss_done = d; iss_branch = b; iss_target = t; iss_kill = k; iss_sys = s;
    endtask

    // one packet, checked every cycle against values derived from R2..R13
    task automatic run_packet(input logic [63:0] pkt, input string tag,
                              input int d1, input logic b1, input logic [31:0] t1,
                              input logic k1, input logic s1,
                              input int d2, input logic b2, input logic [31:0] t2);
        logic [1:0]  fmt;
        logic [63:0] w1, w2;
        logic [1:0]  u1, u2;
        logic        wide, second, xb, xc;
        logic [31:0] xpc;
        fmt  = {pkt[63], pkt[31]};                     // R2 decode
        wide = (fmt == 2'd3);
        w2 = '0; u2 = 2'd0;
        case (fmt)
            2'd0: begin w1 = {32'b0, pkt[63:32]}; u1 = 2'd1; w2 = {32'b0, pkt[31:0]}; u2 = 2'd2; end // R7
            2'd1: begin w1 = {32'b0, pkt[63:32]}; u1 = 2'd1; w2 = {32'b0, pkt[31:0]}; u2 = 2'd0; end // R3
            2'd2: begin w1 = {32'b0, pkt[31:0]};  u1 = 2'd2; w2 = {32'b0, pkt[63:32]}; u2 = 2'd0; end // R4
            default: begin w1 = pkt; u1 = 2'd0; end                                             // R5
        endcase
        second = (fmt == 2'd0) || (!wide && !b1 && !k1);  // R6
        if (fmt == 2'd0) begin                            // R8
            xc  = b1 & b2;
            xb  = b1 ^ b2;
            xpc = (b1 && !b2) ? t1 : ((b2 && !b1) ? t2 : 32'd0);
        end else begin                                    // R9
            xc  = 1'b0;
            xb  = b1 | (second & b2);
            xpc = b1 ? t1 : ((second && b2) ? t2 : 32'd0);
        end

        // IDLE: offer packet
        quiet_exp(); e_ready = 1;
        pkt_valid = 1; pkt_data = pkt;
        step({tag, " accept R1"});
        // stray packet while busy must be ignored (R11)
        pkt_data = ~pkt;
        // first issue
        quiet_exp(); e_ivalid = 1; e_word = w1; e_unit = u1; e_long = wide;
        for (int i = 0; i < d1; i++) step({tag, " first-wait R11"});
        respond(1, b1, t1, k1, s1);
        step({tag, " first-done R3 R4 R5 R7"});
        respond(0, 0, 32'd0, 0, 0);
        pkt_valid = 0;
        if (second) begin
            quiet_exp(); e_ivalid = 1; e_word = w2; e_unit = u2;
            e_kill = k1; e_sys = s1;                      // R12
            e_commit = (fmt != 2'd0);                     // R10
            for (int i = 0; i < d2; i++) begin
                step({tag, " second-wait R10 R11 R12"});
                e_commit = 0;
            end
            respond(1, b2, t2, 0, 0);
            step({tag, " second-done R6 R10"});
            respond(0, 0, 32'd0, 0, 0);
        end
        // result cycle
        quiet_exp(); e_rvalid = 1; e_rbr = xb; e_rpc = xpc; e_rconf = xc;
        e_commit = 1; e_kill = k1; e_sys = s1;
        step({tag, " result R6 R8 R9 R10 R12 R13"});
    endtask

    initial begin
        quiet_exp();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        quiet_exp(); e_ready = 1;
        step("reset R1");

        // R3 upper-first, no branches
        run_packet({1'b0, 31'h1234_5678, 1'b1, 31'h0BAD_CAFE}, "R3 lr-plain", 0, 0, 0, 0, 0, 0, 0, 0);
        // R4 lower-first, waits, no branches
        run_packet({1'b1, 31'h2222_1111, 1'b0, 31'h3333_4444}, "R4 rl-plain", 2, 0, 0, 0, 0, 3, 0, 0);
        // R6 first branch cancels second
        run_packet({1'b0, 31'h0000_00AA, 1'b1, 31'h0000_00BB}, "R6 lr-branch", 1, 1, 32'h0000_4000, 0, 0, 0, 0, 0);
        // R6 kill-only cancels second, no branch, R12 flag held
        run_packet({1'b1, 31'h0000_0CCC, 1'b0, 31'h0000_0DDD}, "R6 rl-kill", 0, 0, 32'hFFFF_0000, 1, 1, 0, 0, 0);
        // R9 second half branches
        run_packet({1'b0, 31'h5555_0001, 1'b1, 31'h6666_0002}, "R9 lr-second-branch", 0, 0, 0, 0, 1, 1, 1, 32'h0000_8888);
        // R5 wide, branch
        run_packet({1'b1, 31'h7000_0007, 1'b1, 31'h0800_0008}, "R5 wide-branch", 2, 1, 32'hDEAD_BEE0, 0, 0, 0, 0, 0);
        // R5 wide, no branch
        run_packet({1'b1, 31'h0000_1111, 1'b1, 31'h0000_2222}, "R5 wide-plain", 0, 0, 0, 0, 0, 0, 0, 0);
        // R7 R8 parallel combinations
        run_packet({1'b0, 31'h0101_0101, 1'b0, 31'h0202_0202}, "R8 par-none", 0, 0, 0, 0, 0, 0, 0, 0);
        run_packet({1'b0, 31'h0303_0303, 1'b0, 31'h0404_0404}, "R8 par-left", 1, 1, 32'h0000_1000, 0, 1, 0, 0, 0);
        run_packet({1'b0, 31'h0505_0505, 1'b0, 31'h0606_0606}, "R8 par-right", 0, 0, 0, 1, 0, 2, 1, 32'h0000_2000);
        run_packet({1'b0, 31'h0707_0707, 1'b0, 31'h0808_0808}, "R8 par-conflict", 0, 1, 32'h0000_3000, 0, 0, 0, 1, 32'h0000_3004);

        // back-to-back random packets
        for (int n = 0; n < 60; n++) begin
            logic [63:0] p;
            p = {$urandom, $urandom};
            run_packet(p, "R2 random",
                       int'($urandom % 3), 1'($urandom % 3 == 0), $urandom,
                       1'($urandom % 4 == 0), 1'($urandom % 2),
                       int'($urandom % 3), 1'($urandom % 2), $urandom);
        end

        quiet_exp(); e_ready = 1;
        step("final idle R1 R12");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule